// File: doc/BRIEF.md
# Memory Initialization Sequencer

This block sits between the power-on reset of a chip and an external block memory that holds processor code or data. After power-up it keeps the memory in reset and waits for a supply-good indication. It then holds reset for a minimum time, writes a short list of configuration words into the memory's configuration port, and fills every word of the array with a fixed value. Finally it releases the memory reset, raises a ready flag, and lets the processor out of reset one cycle later.

A completion flag is cleared only by power-on reset. Any later system reset sends the sequencer back to its idle state, but the memory is not touched again. Ready is raised again straight away, and the processor is released right after it. A system reset that arrives before the first bring-up has finished restarts the whole bring-up.

Top module: `mem_init_sequencer`

## Requirements
- R1: While `por_n` is low, `mem_rst` is 1, `ready` is 0, `cpu_rst_n` is 0, and `cfg_we` and `wr_en` are both 0.
- R2: After power-on, while `supply_ok` is 0, no write of either kind occurs, `mem_rst` stays 1, and `ready` stays 0.
- R3: Once `supply_ok` is sampled high in idle, at least `HOLD_CYC` cycles pass with `mem_rst` at 1 before the first configuration write. The hold count restarts after a system reset.
- R4: Configuration writes come next. `cfg_we` is high for `CFG_N` consecutive cycles. Entry i (i = 0 first) drives `cfg_addr` with bits [i*CFG_AW +: CFG_AW] of `CFG_ADDRS` and `cfg_data` with bits [i*CFG_DW +: CFG_DW] of `CFG_DATAS`. Throughout, `mem_rst` is 1 and `wr_en` is 0.
- R5: Directly after the last configuration write, `wr_en` is high for `DEPTH` consecutive cycles. `wr_addr` runs 0, 1, …, `DEPTH`-1, and `wr_data` is `FILL_VAL`, with `mem_rst` at 1.
- R6: `mem_rst` falls in the cycle after the last fill write, and `ready` rises exactly one cycle after `mem_rst` falls.
- R7: `cpu_rst_n` rises exactly one cycle after `ready` rises, provided `sys_rst_n` stays high. Both then stay high until a reset.
- R8: After bring-up has completed, a low `sys_rst_n` forces `ready` and `cpu_rst_n` to 0. While it is low and after it is released, `mem_rst` stays 0 and no write occurs. `ready` is back at 1 one cycle after `sys_rst_n` is sampled high.
- R9: A low `sys_rst_n` before bring-up has completed keeps `mem_rst` at 1. After its release, the full sequence R3–R7 runs again from the start.
- R10: A new power-on reset clears the completion flag, and the full sequence R3–R7 runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst_n | input | 1 | System reset, synchronous, active low |
| supply_ok | input | 1 | Memory supply reported within range |
| mem_rst | output | 1 | Reset to the memory, active high |
| cfg_we | output | 1 | Configuration write strobe |
| cfg_addr | output | CFG_AW | Configuration register address |
| cfg_data | output | CFG_DW | Configuration register value |
| wr_en | output | 1 | Array write strobe |
| wr_addr | output | $clog2(DEPTH) | Array write address |
| wr_data | output | DW | Array write data |
| ready | output | 1 | Memory usable |
| cpu_rst_n | output | 1 | Processor reset release, active low |

## Verification
A step counter that is out by one shows up as a missing or extra write at the end of a phase. It also shows as a hold window that is too short, which appears at the first configuration strobe. A stale state encoding appears within one cycle as `ready` or `cpu_rst_n` moving out of order with `mem_rst`. A completion flag that is wrong is only exposed at the next reset: a later system reset produces a fresh burst of writes and a `mem_rst` pulse, and a new power-on produces no writes.

// File: rtl/mis_pkg.sv
package mis_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HOLD  = 3'd1,
        ST_CFG   = 3'd2,
        ST_FILL  = 3'd3,
        ST_REL   = 3'd4,
        ST_READY = 3'd5,
        ST_RUN   = 3'd6
    } seq_state_e;

endpackage

// File: rtl/mis_cfg_rom.sv
module mis_cfg_rom #(
    parameter int              N     = 4,
    parameter int              AW    = 8,
    parameter int              DW    = 16,
    parameter int              IW    = 2,
    parameter logic [N*AW-1:0] ADDRS = '0,
    parameter logic [N*DW-1:0] DATAS = '0
) (
    input  logic [IW-1:0] idx,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data
);

    logic [AW-1:0] addr_tab [N];
    logic [DW-1:0] data_tab [N];

    for (genvar g = 0; g < N; g++) begin : g_unpack
        assign addr_tab[g] = ADDRS[g*AW +: AW];
        assign data_tab[g] = DATAS[g*DW +: DW];
    end

    always_comb begin
        addr = '0;
        data = '0;
        for (int i = 0; i < N; i++) begin
            if (int'(idx) == i) begin
                addr = addr_tab[i];
                data = data_tab[i];
            end
        end
    end

endmodule

// File: rtl/mis_done_flag.sv
module mis_done_flag (
    input  logic clk,
    input  logic por_n,
    input  logic set,
    output logic done
);

    logic done_d, done_q;

    always_comb begin
        done_d = done_q | set;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= done_d;
        end
    end

    assign done = done_q;

endmodule

// File: rtl/mis_out_decode.sv
module mis_out_decode
    import mis_pkg::*;
(
    input  seq_state_e st,
    input  logic       done,
    output logic       mem_rst,
    output logic       cfg_we,
    output logic       wr_en,
    output logic       ready,
    output logic       cpu_rst_n
);

    always_comb begin
        mem_rst   = 1'b0;
        cfg_we    = 1'b0;
        wr_en     = 1'b0;
        ready     = 1'b0;
        cpu_rst_n = 1'b0;
        unique case (st)
            ST_IDLE:  mem_rst = !done;
            ST_HOLD:  mem_rst = 1'b1;
            ST_CFG: begin
                mem_rst = 1'b1;
                cfg_we  = 1'b1;
            end
            ST_FILL: begin
                mem_rst = 1'b1;
                wr_en   = 1'b1;
            end
            ST_REL:   ;
            ST_READY: ready = 1'b1;
            ST_RUN: begin
                ready     = 1'b1;
                cpu_rst_n = 1'b1;
            end
            default:  mem_rst = 1'b1;
        endcase
    end

endmodule

// File: rtl/mem_init_sequencer.sv
module mem_init_sequencer
    import mis_pkg::*;
#(
    parameter int                    DEPTH     = 16,
    parameter int                    DW        = 32,
    parameter logic [DW-1:0]         FILL_VAL  = '0,
    parameter int                    HOLD_CYC  = 8,
    parameter int                    CFG_N     = 4,
    parameter int                    CFG_AW    = 8,
    parameter int                    CFG_DW    = 16,
    parameter logic [CFG_N*CFG_AW-1:0] CFG_ADDRS = {8'h30, 8'h20, 8'h10, 8'h04},
    parameter logic [CFG_N*CFG_DW-1:0] CFG_DATAS = {16'hD00D, 16'hC0DE, 16'hBEEF, 16'hA5A5},
    localparam int                   AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              supply_ok,
    output logic              mem_rst,
    output logic              cfg_we,
    output logic [CFG_AW-1:0] cfg_addr,
    output logic [CFG_DW-1:0] cfg_data,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [DW-1:0]     wr_data,
    output logic              ready,
    output logic              cpu_rst_n
);

    localparam int CNT_MAX = (DEPTH > HOLD_CYC) ? ((DEPTH > CFG_N) ? DEPTH : CFG_N)
                                                : ((HOLD_CYC > CFG_N) ? HOLD_CYC : CFG_N);
    localparam int CW      = $clog2(CNT_MAX) + 1;
    localparam int CIW     = (CFG_N > 1) ? $clog2(CFG_N) : 1;

    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] CFG_LAST  = CW'(CFG_N - 1);
    localparam logic [CW-1:0] FILL_LAST = CW'(DEPTH - 1);

    typedef struct packed {
        seq_state_e      st;
        logic [CW-1:0]   cnt;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic      done_q;
    logic      done_set;

    // next-state computation
    always_comb begin
        seq_d    = seq_q;
        done_set = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (done_q) begin
                    seq_d.st = ST_READY;
                end else if (supply_ok) begin
                    seq_d.st  = ST_HOLD;
                    seq_d.cnt = '0;
                end
            end
            ST_HOLD: begin
                if (seq_q.cnt == HOLD_LAST) begin
                    seq_d.st  = ST_CFG;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_CFG: begin
                if (seq_q.cnt == CFG_LAST) begin
                    seq_d.st  = ST_FILL;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_FILL: begin
                if (seq_q.cnt == FILL_LAST) begin
                    seq_d.st  = ST_REL;
                    seq_d.cnt = '0;
                    done_set  = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_REL:   seq_d.st = ST_READY;
            ST_READY: seq_d.st = ST_RUN;
            ST_RUN:   seq_d.st = ST_RUN;
            default:  seq_d.st = ST_IDLE;
        endcase
        if (!sys_rst_n) begin
            seq_d.st  = ST_IDLE;
            seq_d.cnt = '0;
            done_set  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            seq_q.st  <= ST_IDLE;
            seq_q.cnt <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    mis_done_flag u_done (
        .clk   (clk),
        .por_n (por_n),
        .set   (done_set),
        .done  (done_q)
    );

    mis_cfg_rom #(
        .N     (CFG_N),
        .AW    (CFG_AW),
        .DW    (CFG_DW),
        .IW    (CIW),
        .ADDRS (CFG_ADDRS),
        .DATAS (CFG_DATAS)
    ) u_rom (
        .idx  (seq_q.cnt[CIW-1:0]),
        .addr (cfg_addr),
        .data (cfg_data)
    );

    mis_out_decode u_dec (
        .st        (seq_q.st),
        .done      (done_q),
        .mem_rst   (mem_rst),
        .cfg_we    (cfg_we),
        .wr_en     (wr_en),
        .ready     (ready),
        .cpu_rst_n (cpu_rst_n)
    );

    assign wr_addr = seq_q.cnt[AW-1:0];
    assign wr_data = FILL_VAL;

endmodule

// File: rtl/mis_seq_checker.sv
module mis_seq_checker #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          por_n,
    input logic          sys_rst_n,
    input logic          mem_rst,
    input logic          cfg_we,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          ready,
    input logic          cpu_rst_n,
    input logic          done
);

    AST_CFG_UNDER_RST: assert property (@(posedge clk) disable iff (!por_n)
        cfg_we |-> (mem_rst && !wr_en)); // R4

    AST_FILL_UNDER_RST: assert property (@(posedge clk) disable iff (!por_n)
        wr_en |-> mem_rst); // R5

    AST_FILL_ADDR_STEP: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == AW'($past(wr_addr) + 1'b1))); // R5

    AST_READY_AFTER_REL: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(mem_rst) && sys_rst_n) |=> ready); // R6

    AST_READY_NO_MEMRST: assert property (@(posedge clk) disable iff (!por_n)
        ready |-> !mem_rst); // R6

    AST_CPU_AFTER_READY: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(ready) && sys_rst_n) |=> cpu_rst_n); // R7

    AST_CPU_NEEDS_READY: assert property (@(posedge clk) disable iff (!por_n)
        cpu_rst_n |-> ready); // R7

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!por_n)
        done |-> (!mem_rst && !cfg_we && !wr_en)); // R8

endmodule

bind mem_init_sequencer mis_seq_checker #(.AW(AW)) u_seq_chk (
    .clk       (clk),
    .por_n     (por_n),
    .sys_rst_n (sys_rst_n),
    .mem_rst   (mem_rst),
    .cfg_we    (cfg_we),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .ready     (ready),
    .cpu_rst_n (cpu_rst_n),
    .done      (done_q)
);

// File: tb/tb_mem_init_sequencer.sv
`timescale 1ns/1ps
module tb_mem_init_sequencer;

    localparam int           DEPTH    = 16;
    localparam int           DW       = 32;
    localparam logic [31:0]  FILL_VAL = 32'h5A5A_0F0F;
    localparam int           HOLD_CYC = 8;
    localparam int           CFG_N    = 4;
    localparam int           AW       = 4;
    localparam logic [7:0]   EXP_CA [CFG_N] = '{8'h04, 8'h10, 8'h20, 8'h30};
    localparam logic [15:0]  EXP_CD [CFG_N] = '{16'hA5A5, 16'hBEEF, 16'hC0DE, 16'hD00D};

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          sys_rst_n = 1'b1;
    logic          supply_ok = 1'b0;
    logic          mem_rst, cfg_we, wr_en, ready, cpu_rst_n;
    logic [7:0]    cfg_addr;
    logic [15:0]   cfg_data;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    always #5 clk = ~clk;

    mem_init_sequencer #(
        .DEPTH    (DEPTH),
        .DW       (DW),
        .FILL_VAL (FILL_VAL),
        .HOLD_CYC (HOLD_CYC),
        .CFG_N    (CFG_N)
    ) dut (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .supply_ok (supply_ok),
        .mem_rst   (mem_rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_data  (cfg_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ready     (ready),
        .cpu_rst_n (cpu_rst_n)
    );

    typedef struct packed {
        logic        is_cfg;
        logic [15:0] addr;
        logic [31:0] data;
    } item_t;

    item_t exp_q[$];
    int    total = 0;
    int    bad   = 0;
    bit    pre_armed = 1'b0;
    int    pre_cnt   = 0;
    bit    mr_hi     = 1'b0;
    bit    prev_mr   = 1'b1;
    bit    prev_rdy  = 1'b0;
    bit    want_rdy  = 1'b0;
    bit    want_cpu  = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // driver: queue the writes a full bring-up must produce
    task automatic expect_full_init();
        item_t it;
        for (int i = 0; i < CFG_N; i++) begin
            it.is_cfg = 1'b1;
            it.addr   = 16'(EXP_CA[i]);
            it.data   = 32'(EXP_CD[i]);
            exp_q.push_back(it);
        end
        for (int i = 0; i < DEPTH; i++) begin
            it.is_cfg = 1'b0;
            it.addr   = 16'(i);
            it.data   = FILL_VAL;
            exp_q.push_back(it);
        end
        pre_armed = 1'b1;
        pre_cnt   = 0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wait_ready(input int limit, input string req);
        int i;
        for (i = 0; i < limit; i++) begin
            @(negedge clk);
            if (ready) break;
        end
        check(ready == 1'b1, req, "ready reached", 64'(ready), 64'd1);
        #1;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        item_t got, e;
        if (!por_n) begin
            prev_mr  = 1'b1;
            prev_rdy = 1'b0;
            want_rdy = 1'b0;
            want_cpu = 1'b0;
            pre_cnt  = 0;
        end else begin
            if (mem_rst) mr_hi = 1'b1;
            if (cfg_we || wr_en) begin
                got.is_cfg = cfg_we;
                got.addr   = cfg_we ? 16'(cfg_addr) : 16'(wr_addr);
                got.data   = cfg_we ? 32'(cfg_data) : wr_data;
                check(!(cfg_we && wr_en), "R4", "single strobe", 64'({cfg_we, wr_en}), 64'd0);
                check(mem_rst == 1'b1, got.is_cfg ? "R4" : "R5", "write under reset",
                      64'(mem_rst), 64'd1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected write", 64'(got), 64'd0);
                end else begin
                    e = exp_q.pop_front();
                    check(got == e, e.is_cfg ? "R4" : "R5", "write item", 64'(got), 64'(e));
                end
            end
            // R3 hold window
            if (!sys_rst_n) begin
                pre_cnt = 0;
            end else if (pre_armed && supply_ok) begin
                if (cfg_we) begin
                    check(pre_cnt >= HOLD_CYC, "R3", "hold cycles", 64'(pre_cnt), 64'(HOLD_CYC));
                    pre_armed = 1'b0;
                end else if (mem_rst) begin
                    pre_cnt++;
                end
            end
            // R6 / R7 ordering
            if (want_rdy) begin
                check(ready == 1'b1, "R6", "ready one cycle after release", 64'(ready), 64'd1);
                want_rdy = 1'b0;
            end
            if (want_cpu) begin
                check(cpu_rst_n == 1'b1, "R7", "cpu release after ready", 64'(cpu_rst_n), 64'd1);
                want_cpu = 1'b0;
            end
            if (prev_mr && !mem_rst && sys_rst_n) begin
                check(ready == 1'b0, "R6", "ready low at release", 64'(ready), 64'd0);
                want_rdy = 1'b1;
            end
            if (!prev_rdy && ready && sys_rst_n) begin
                check(cpu_rst_n == 1'b0, "R7", "cpu held when ready rises", 64'(cpu_rst_n), 64'd0);
                want_cpu = 1'b1;
            end
            prev_mr  = mem_rst;
            prev_rdy = ready;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 power-on state
        step(3);
        check(mem_rst == 1'b1, "R1", "mem_rst in por", 64'(mem_rst), 64'd1);
        check(ready == 1'b0, "R1", "ready in por", 64'(ready), 64'd0);
        check(cpu_rst_n == 1'b0, "R1", "cpu in por", 64'(cpu_rst_n), 64'd0);
        check(!cfg_we && !wr_en, "R1", "no strobes in por", 64'({cfg_we, wr_en}), 64'd0);
        por_n = 1'b1;

        // R2 waits for supply
        step(10);
        check(mem_rst == 1'b1, "R2", "mem_rst without supply", 64'(mem_rst), 64'd1);
        check(ready == 1'b0, "R2", "ready without supply", 64'(ready), 64'd0);

        // first bring-up: R3..R7
        expect_full_init();
        supply_ok = 1'b1;
        wait_ready(HOLD_CYC + CFG_N + DEPTH + 10, "R6");
        check(exp_q.size() == 0, "R5", "all writes seen", 64'(exp_q.size()), 64'd0);
        check(pre_armed == 1'b0, "R3", "config started", 64'(pre_armed), 64'd0);
        step(1);
        for (int i = 0; i < 4; i++) begin
            check(ready && cpu_rst_n, "R7", "stay released", 64'({ready, cpu_rst_n}), 64'd3);
            step(1);
        end

        // R8 later system reset skips bring-up
        mr_hi = 1'b0;
        sys_rst_n = 1'b0;
        step(3);
        check(ready == 1'b0 && cpu_rst_n == 1'b0, "R8", "outputs in sys reset",
              64'({ready, cpu_rst_n}), 64'd0);
        check(mem_rst == 1'b0, "R8", "mem stays out of reset", 64'(mem_rst), 64'd0);
        sys_rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b1, "R8", "ready right after release", 64'(ready), 64'd1);
        step(3);
        check(cpu_rst_n == 1'b1, "R8", "cpu released", 64'(cpu_rst_n), 64'd1);
        check(mr_hi == 1'b0, "R8", "no memory reset pulse", 64'(mr_hi), 64'd0);
        check(exp_q.size() == 0, "R8", "no writes", 64'(exp_q.size()), 64'd0);

        // R10 new power-on reruns everything
        por_n = 1'b0;
        step(2);
        expect_full_init();
        por_n = 1'b1;
        wait_ready(HOLD_CYC + CFG_N + DEPTH + 10, "R10");
        check(exp_q.size() == 0, "R10", "full rerun", 64'(exp_q.size()), 64'd0);
        step(2);

        // R9 system reset during hold restarts bring-up
        por_n = 1'b0;
        supply_ok = 1'b0;
        step(2);
        expect_full_init();
        por_n = 1'b1;
        step(1);
        supply_ok = 1'b1;
        step(4);
        sys_rst_n = 1'b0;
        step(4);
        check(mem_rst == 1'b1, "R9", "mem held in early sys reset", 64'(mem_rst), 64'd1);
        check(!cfg_we && !wr_en, "R9", "no writes in sys reset", 64'({cfg_we, wr_en}), 64'd0);
        sys_rst_n = 1'b1;
        wait_ready(HOLD_CYC + CFG_N + DEPTH + 10, "R9");
        check(exp_q.size() == 0, "R9", "restarted sequence", 64'(exp_q.size()), 64'd0);
        step(2);
        check(cpu_rst_n == 1'b1, "R9", "cpu released", 64'(cpu_rst_n), 64'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule